// File: doc/BRIEF.md
# Inner Data Label Classifier

This block sits on the byte stream of an encapsulated data frame. The stream starts at the inner destination MAC address. The block skips the two 6-byte inner MAC addresses and reads the tag type that follows them. From that tag type it decides whether the frame carries a coarse 12-bit VLAN label, a fine 24-bit label split into two parts, or neither. When the frame carries neither, it is marked for discard.

Bytes pass straight through from input to output, and backpressure travels back the same way. The block only watches the accepted beats. Once a frame's label has been decoded, or the frame has been found malformed, a one-cycle metadata pulse presents four things:
- the class,
- the label,
- the forwarding priority,
- the drop-eligibility bit.

Downstream logic uses this pulse to queue, filter or drop the frame.

Top module: `lbl_classifier`

## Requirements
- R1: The output stream carries the input stream unchanged in the same cycle: out_valid_o equals in_valid_i, out_data_o equals in_data_i, out_last_o equals in_last_i, and in_ready_o equals out_ready_i.
- R2: When bytes 12 and 13 of the frame (most significant byte first) are 0x8100, the class is coarse (code 1). The label is the low 12 bits of the 16-bit field in bytes 14 and 15, with label bits 23:12 zero.
- R3: For a coarse frame, the priority is bits 15:13 and the drop-eligibility bit is bit 12 of the field in bytes 14 and 15.
- R4: When bytes 12 and 13 are 0x893B, the class is fine (code 2). Bytes 14 and 15 hold the high part and bytes 18 and 19 hold the low part. The label is the high part's low 12 bits placed above the low part's low 12 bits.
- R5: For a fine frame, the priority and drop-eligibility bit come from bits 15:13 and bit 12 of the high part. The upper 4 bits of the low part have no effect on the metadata.
- R6: When bytes 12 and 13 hold any other value, the class is malformed (code 3), and the label, priority and drop-eligibility bit are all zero. The decision is made on byte 13, and later bytes have no effect on the metadata.
- R7: A fine frame whose bytes 16 and 17 are not 0x893B is malformed, with zero label, priority and drop-eligibility bit.
- R8: A frame whose last byte arrives before its label field is complete is malformed. This covers a frame that ends before byte 15 for coarse, and before byte 19 for fine.
- R9: meta_valid_o is high for exactly one cycle per frame. It rises in the cycle after the accepted beat that settles the decision.
- R10: Stall cycles, where in_valid_i is high but out_ready_i is low, do not advance the parse. The metadata is the same as for the same frame sent without stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with in_valid_i |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Final byte of the frame |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the frame on the output |
| meta_valid_o | output | 1 | One-cycle metadata strobe |
| meta_class_o | output | 2 | 1 coarse, 2 fine, 3 malformed |
| meta_label_o | output | 24 | Decoded label |
| meta_prio_o | output | 3 | Forwarding priority |
| meta_dei_o | output | 1 | Drop-eligibility bit |

## Verification
The assertions check the following on every cycle:
- a metadata strobe is a single cycle;
- a strobe always follows an accepted beat;
- a coarse result never has a nonzero upper label half;
- a malformed result carries no label, priority or drop-eligibility bit.

Only the bench scenarios can show the following:
- that the correct byte positions are picked;
- that the second tag of a fine frame is checked;
- that frames cut short are rejected;
- that stalls leave the decode unchanged.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
  typedef enum logic [1:0] {
    LBL_NONE   = 2'd0,
    LBL_COARSE = 2'd1,
    LBL_FINE   = 2'd2,
    LBL_BAD    = 2'd3
  } lbl_class_e;

  typedef struct packed {
    lbl_class_e  cls;
    logic [23:0] label;
    logic [2:0]  prio;
    logic        dei;
  } lbl_meta_t;

  localparam lbl_meta_t META_BAD = '{cls: LBL_BAD, label: 24'd0, prio: 3'd0, dei: 1'b0};
endpackage

// File: rtl/lbl_beat_cnt.sv
module lbl_beat_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pos_q <= '0;
    else if (fire_i && last_i)  pos_q <= '0;
    else if (fire_i && pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/lbl_decode.sv
module lbl_decode
  import lbl_pkg::*;
#(
  parameter int          TAG_OFS   = 12,
  parameter int          CNT_W     = 5,
  parameter logic [15:0] TYPE_VLAN = 16'h8100,
  parameter logic [15:0] TYPE_FINE = 16'h893B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             last_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] pos_i,
  output logic             decide_o,
  output lbl_meta_t        meta_o
);
  // Odd offsets close a 16-bit word: tag, first field, second tag, second field
  localparam logic [CNT_W-1:0] P_TAG  = CNT_W'(TAG_OFS + 1);
  localparam logic [CNT_W-1:0] P_FLD1 = CNT_W'(TAG_OFS + 3);
  localparam logic [CNT_W-1:0] P_TAG2 = CNT_W'(TAG_OFS + 5);
  localparam logic [CNT_W-1:0] P_FLD2 = CNT_W'(TAG_OFS + 7);

  logic [7:0]  byte_q;
  logic [15:0] tag_q, hi_q;
  logic        done_q;
  logic [15:0] word;
  logic        hit;
  lbl_meta_t   hit_meta;

  assign word = {byte_q, data_i};

  always_comb begin
    hit      = 1'b0;
    hit_meta = META_BAD;
    if (fire_i && !done_q) begin
      unique case (pos_i)
        P_TAG:  hit = (word != TYPE_VLAN) && (word != TYPE_FINE);
        P_FLD1: if (tag_q == TYPE_VLAN) begin
                  hit      = 1'b1;
                  hit_meta = '{cls: LBL_COARSE, label: {12'd0, word[11:0]},
                               prio: word[15:13], dei: word[12]};
                end
        P_TAG2: hit = (word != TYPE_FINE);
        P_FLD2: begin
                  hit      = 1'b1;
                  hit_meta = '{cls: LBL_FINE, label: {hi_q[11:0], word[11:0]},
                               prio: hi_q[15:13], dei: hi_q[12]};
                end
        default: ;
      endcase
      // truncated frame
      if (!hit && last_i) begin
        hit      = 1'b1;
        hit_meta = META_BAD;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      tag_q  <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
    end else if (fire_i) begin
      byte_q <= data_i;
      if (pos_i == P_TAG)  tag_q <= word;
      if (pos_i == P_FLD1) hi_q  <= word;
      if (last_i)   done_q <= 1'b0;
      else if (hit) done_q <= 1'b1;
    end
  end

  assign decide_o = hit;
  assign meta_o   = hit_meta;
endmodule

// File: rtl/lbl_classifier.sv
module lbl_classifier
  import lbl_pkg::*;
#(
  parameter int          TAG_OFS   = 12,
  parameter logic [15:0] TYPE_VLAN = 16'h8100,
  parameter logic [15:0] TYPE_FINE = 16'h893B
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [7:0]  out_data_o,
  output logic        out_last_o,
  output logic        meta_valid_o,
  output logic [1:0]  meta_class_o,
  output logic [23:0] meta_label_o,
  output logic [2:0]  meta_prio_o,
  output logic        meta_dei_o
);
  localparam int CNT_W = $clog2(TAG_OFS + 9);

  logic             fire;
  logic [CNT_W-1:0] pos;
  logic             decide;
  lbl_meta_t        meta_d, meta_q;
  logic             mvalid_q;

  assign out_valid_o = in_valid_i;
  assign out_data_o  = in_data_i;
  assign out_last_o  = in_last_i;
  assign in_ready_o  = out_ready_i;
  assign fire        = in_valid_i && out_ready_i;

  lbl_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .last_i (in_last_i),
    .pos_o  (pos)
  );

  lbl_decode #(
    .TAG_OFS   (TAG_OFS),
    .CNT_W     (CNT_W),
    .TYPE_VLAN (TYPE_VLAN),
    .TYPE_FINE (TYPE_FINE)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .last_i   (in_last_i),
    .data_i   (in_data_i),
    .pos_i    (pos),
    .decide_o (decide),
    .meta_o   (meta_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mvalid_q <= 1'b0;
      meta_q   <= '{cls: LBL_NONE, label: 24'd0, prio: 3'd0, dei: 1'b0};
    end else begin
      mvalid_q <= decide;
      if (decide) meta_q <= meta_d;
    end
  end

  assign meta_valid_o = mvalid_q;
  assign meta_class_o = meta_q.cls;
  assign meta_label_o = meta_q.label;
  assign meta_prio_o  = meta_q.prio;
  assign meta_dei_o   = meta_q.dei;
endmodule

// File: rtl/lbl_classifier_chk.sv
module lbl_classifier_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        meta_valid_o,
  input logic [1:0]  meta_class_o,
  input logic [23:0] meta_label_o,
  input logic [2:0]  meta_prio_o,
  input logic        meta_dei_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R9
  meta_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meta_valid_o |=> !meta_valid_o);

  // R9
  meta_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meta_valid_o && started_q) |-> $past(in_valid_i && in_ready_o));

  // R2
  coarse_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meta_valid_o && meta_class_o == 2'd1) |-> (meta_label_o[23:12] == 12'd0));

  // R6
  bad_fields_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meta_valid_o && meta_class_o == 2'd3) |->
      (meta_label_o == 24'd0 && meta_prio_o == 3'd0 && !meta_dei_o));

  // R9
  class_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meta_valid_o |-> (meta_class_o != 2'd0));
endmodule

bind lbl_classifier lbl_classifier_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .meta_valid_o (meta_valid_o),
  .meta_class_o (meta_class_o),
  .meta_label_o (meta_label_o),
  .meta_prio_o  (meta_prio_o),
  .meta_dei_o   (meta_dei_o)
);

// File: tb/lbl_classifier_bench.sv
module lbl_classifier_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [7:0]  out_data_o;
  logic        out_last_o;
  logic        meta_valid_o;
  logic [1:0]  meta_class_o;
  logic [23:0] meta_label_o;
  logic [2:0]  meta_prio_o;
  logic        meta_dei_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pulses = 0;
  logic [1:0]  cap_cls;
  logic [23:0] cap_lbl;
  logic [2:0]  cap_pri;
  logic        cap_dei;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lbl_classifier u_lbl_classifier (.*);

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (meta_valid_o) begin
      pulses  <= pulses + 1;
      cap_cls <= meta_class_o;
      cap_lbl <= meta_label_o;
      cap_pri <= meta_prio_o;
      cap_dei <= meta_dei_o;
    end
  end

  typedef struct packed {
    logic [15:0] tag;
    logic [15:0] f1;
    logic [15:0] tag2;
    logic [15:0] f2;
    logic [7:0]  len;
    logic        stall;
    logic [1:0]  cls;
    logic [23:0] lbl;
    logic [2:0]  pri;
    logic        dei;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h8100, 16'hA123, 16'h0000, 16'h0000, 8'd24, 1'b0, 2'd1, 24'h000123, 3'd5, 1'b0}, // R2 R3
    '{16'h8100, 16'h3FFF, 16'h0000, 16'h0000, 8'd16, 1'b0, 2'd1, 24'h000FFF, 3'd1, 1'b1}, // R2 exact end
    '{16'h893B, 16'hE456, 16'h893B, 16'h1789, 8'd30, 1'b0, 2'd2, 24'h456789, 3'd7, 1'b0}, // R4 R5
    '{16'h893B, 16'h5ABC, 16'h893B, 16'hFDEF, 8'd20, 1'b1, 2'd2, 24'hABCDEF, 3'd2, 1'b1}, // R4 R10
    '{16'h88A8, 16'hF234, 16'h893B, 16'h0567, 8'd24, 1'b0, 2'd3, 24'h000000, 3'd0, 1'b0}, // R6
    '{16'h893B, 16'h2111, 16'h8100, 16'h0222, 8'd24, 1'b0, 2'd3, 24'h000000, 3'd0, 1'b0}, // R7
    '{16'h8100, 16'h0005, 16'h0000, 16'h0000, 8'd15, 1'b0, 2'd3, 24'h000000, 3'd0, 1'b0}, // R8
    '{16'h893B, 16'h2111, 16'h893B, 16'h0222, 8'd19, 1'b0, 2'd3, 24'h000000, 3'd0, 1'b0}, // R8
    '{16'h8100, 16'h0005, 16'h0000, 16'h0000, 8'd10, 1'b1, 2'd3, 24'h000000, 3'd0, 1'b0}, // R8
    '{16'h893A, 16'hFFFF, 16'h893B, 16'hFFFF, 8'd24, 1'b1, 2'd3, 24'h000000, 3'd0, 1'b0}, // R6
    '{16'h8100, 16'hC0AB, 16'h893B, 16'h1234, 8'd40, 1'b1, 2'd1, 24'h0000AB, 3'd6, 1'b0}  // R10
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input vec_t v, input int i);
    case (i)
      12: return v.tag[15:8];
      13: return v.tag[7:0];
      14: return v.f1[15:8];
      15: return v.f1[7:0];
      16: return v.tag2[15:8];
      17: return v.tag2[7:0];
      18: return v.f2[15:8];
      19: return v.f2[7:0];
      default: return (i < 12) ? 8'(8'h10 + i) : 8'(8'hC0 ^ i);
    endcase
  endfunction

  task automatic send(input vec_t v, output int pt_err);
    pt_err = 0;
    for (int i = 0; i < int'(v.len); i++) begin
      bit taken = 1'b0;
      while (!taken) begin
        @(negedge clk_i);
        in_valid_i  = 1'b1;
        in_data_i   = frame_byte(v, i);
        in_last_i   = (i == int'(v.len) - 1);
        out_ready_i = v.stall ? ((cyc % 3) != 0) : 1'b1;
        #1;
        // R1
        if (out_valid_o !== 1'b1 || out_data_o !== in_data_i ||
            out_last_o !== in_last_i || in_ready_o !== out_ready_i) pt_err++;
        taken = out_ready_i;
        @(posedge clk_i);
      end
    end
    @(negedge clk_i);
    in_valid_i  = 1'b0;
    in_last_i   = 1'b0;
    out_ready_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pt;
    repeat (3) @(negedge clk_i);
    // reset state
    check(meta_valid_o === 1'b0, "R9 reset strobe", 32'(meta_valid_o), 0);
    check(meta_class_o === 2'd0, "R9 reset class", 32'(meta_class_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    #1;
    check(in_ready_o === 1'b0 && out_valid_o === 1'b0, "R1 idle ready", 32'(in_ready_o), 0);
    out_ready_i = 1'b1;

    for (int k = 0; k < NV; k++) begin
      pulses = 0;
      send(VECS[k], pt);
      repeat (3) @(negedge clk_i);
      check(pt == 0, "R1 passthrough", 32'(pt), 0);
      check(pulses == 1, "R9 one strobe", 32'(pulses), 1);
      check(cap_cls == VECS[k].cls, "R2/R4/R6/R7/R8 class", 32'(cap_cls), 32'(VECS[k].cls));
      check(cap_lbl == VECS[k].lbl, "R2/R4 label", 32'(cap_lbl), 32'(VECS[k].lbl));
      check(cap_pri == VECS[k].pri && cap_dei == VECS[k].dei, "R3/R5 prio dei",
            32'({cap_pri, cap_dei}), 32'({VECS[k].pri, VECS[k].dei}));
    end

    // R9 strobe timing: coarse decision on byte 15, strobe the next cycle
    begin
      vec_t v = VECS[0];
      int seen = -1;
      pulses = 0;
      for (int i = 0; i < 18; i++) begin
        @(negedge clk_i);
        in_valid_i = 1'b1;
        in_data_i  = frame_byte(v, i);
        in_last_i  = (i == 17);
        #1;
        if (meta_valid_o && seen < 0) seen = i;
      end
      @(negedge clk_i);
      in_valid_i = 1'b0;
      in_last_i  = 1'b0;
      check(seen == 16, "R9 strobe cycle", 32'(seen), 16);
    end

    // R6 bytes after a bad tag have no effect: same frame with other payload
    begin
      vec_t v = VECS[4];
      v.f1 = 16'h8100;
      v.f2 = 16'hFFFF;
      pulses = 0;
      send(v, pt);
      repeat (3) @(negedge clk_i);
      check(cap_cls == 2'd3 && cap_lbl == 24'd0 && pulses == 1, "R6 later bytes ignored",
            32'(cap_lbl), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule